// File: doc/BRIEF.md
# Operand Hazard Interlock for a Six-Stage In-Order Pipeline

This block decides, every cycle, where the two source operands of the instruction sitting in the register-read stage must come from, and whether that instruction may advance. The pipeline runs fetch, decode, register read, execute, memory and writeback in order, and operands are read from the register file in the register-read stage. Three older instructions can still be in flight: one in execute (one ahead), one in memory (two ahead) and one in writeback (three ahead). The block compares each source register against the destination of each of them.

The result feeds the operand multiplexers in front of the execute unit. An arithmetic result one ahead is taken straight from the execute output. An arithmetic result two ahead is taken from the memory-stage result. Load data two ahead is taken from the memory read return. A producer three ahead needs no bypass because the register file writes before it reads in the same cycle. A load one ahead cannot be bypassed: the block holds fetch, decode and register read for one cycle and places a bubble into execute. The block is purely combinational and sits beside the pipeline registers it observes.

Top module: `hazard_interlock`

## Requirements
- R1: When the register-read instruction is not valid, both operand selects are 00 (register file) and the stall and bubble outputs are 0, whatever the older stages hold.
- R2: A valid, writing, non-load instruction in execute whose destination equals a source gives that operand select 01 (execute result).
- R3: A valid, writing, non-load instruction in memory whose destination equals a source, with no matching producer in execute, gives select 10 (memory-stage result).
- R4: A matching producer that is only in writeback gives select 00 and causes no stall.
- R5: A valid, writing load in execute whose destination equals either source drives both the upstream stall and the execute bubble to 1, and the select of each operand that matches that load is 00.
- R6: A valid, writing load in memory whose destination equals a source, with no matching producer in execute, gives select 11 (load return data) and no stall.
- R7: Source or destination register 0 never matches, so it never causes a bypass or a stall.
- R8: A producer whose valid or write-enable flag is 0 never matches.
- R9: When several in-flight instructions write the same register, the youngest one decides: execute over memory over writeback.
- R10: Each operand has its own comparison and select; the select of one operand does not depend on the source register of the other.
- R11: The stall and bubble outputs are always equal and are 1 only in the case of R5.
- R12: A load-use dependency costs exactly one stall: once the load has moved to memory and a bubble sits in execute, the same consumer gets select 11 and no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rdValid | input | 1 | Register-read stage holds a real instruction |
| rdSrcA | input | REG_AW | First source register of the register-read instruction |
| rdSrcB | input | REG_AW | Second source register of the register-read instruction |
| exValid | input | 1 | Execute stage holds a real instruction |
| exWrEn | input | 1 | Execute instruction writes a register |
| exIsLoad | input | 1 | Execute instruction is a load |
| exDest | input | REG_AW | Destination register of the execute instruction |
| memValid | input | 1 | Memory stage holds a real instruction |
| memWrEn | input | 1 | Memory instruction writes a register |
| memIsLoad | input | 1 | Memory instruction is a load |
| memDest | input | REG_AW | Destination register of the memory instruction |
| wbValid | input | 1 | Writeback stage holds a real instruction |
| wbWrEn | input | 1 | Writeback instruction writes a register |
| wbDest | input | REG_AW | Destination register of the writeback instruction |
| fwdSelA | output | 2 | Operand A source: 00 register file, 01 execute result, 10 memory result, 11 load data |
| fwdSelB | output | 2 | Operand B source, same encoding |
| stallUpstream | output | 1 | Hold fetch, decode and register read this cycle |
| bubbleAlu | output | 1 | Inject a no-op into execute this cycle |

## Verification
Because the block keeps no state, any internal fault appears at the outputs in the same cycle as the stage contents that provoke it: a wrong priority or comparator shows as a wrong two-bit select, and a missed load check shows as a stall that is absent or one that appears where only a bypass is needed. The bench drives directed stage contents for each bypass distance, for register 0, for disabled producers and for stacked producers of one register, then a long run of random stage contents over a small register range so that matches are frequent. Each output is compared with a model written from the requirements, and a two-step sequence follows a load from execute into memory to confirm a single stall cycle.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  // number of older in-flight instructions compared against register read
  localparam int unsigned NUM_OLDER = 3;
  // producer slot indices, youngest first
  localparam int unsigned SLOT_EX  = 0;
  localparam int unsigned SLOT_MEM = 1;
  localparam int unsigned SLOT_WB  = 2;

  typedef enum logic [1:0] {
    FWD_RF   = 2'b00,
    FWD_EX   = 2'b01,
    FWD_MEM  = 2'b10,
    FWD_LOAD = 2'b11
  } fwdSel_e;

  typedef struct packed {
    logic holdFront;
    logic injectBubble;
  } ctrlStrobes_t;

endpackage

// File: rtl/hzd_match_bank.sv
module hzd_match_bank
  import hazard_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic                               srcValid,
  input  logic [REG_AW-1:0]                  srcReg,
  input  logic [NUM_OLDER-1:0]               prodValid,
  input  logic [NUM_OLDER-1:0]               prodWrEn,
  input  logic [NUM_OLDER-1:0][REG_AW-1:0]   prodDest,
  output logic [NUM_OLDER-1:0]               hit
);

  logic srcLive;
  assign srcLive = srcValid && (srcReg != '0);

  // one comparator per older stage
  for (genvar g = 0; g < NUM_OLDER; g++) begin : gCmp
    logic destEq;
    assign destEq = (prodDest[g] == srcReg);
    assign hit[g] = srcLive && prodValid[g] && prodWrEn[g] && destEq;
  end

endmodule

// File: rtl/hzd_fwd_pick.sv
module hzd_fwd_pick
  import hazard_pkg::*;
(
  input  logic [NUM_OLDER-1:0] hit,
  input  logic                 exIsLoad,
  input  logic                 memIsLoad,
  input  logic                 srcValid,
  output fwdSel_e              sel,
  output logic                 loadUse
);

  always_comb begin
    sel     = FWD_RF;
    loadUse = 1'b0;
    if (hit[SLOT_EX]) begin
      if (exIsLoad) loadUse = 1'b1;
      else          sel     = FWD_EX;
    end else if (hit[SLOT_MEM]) begin
      sel = memIsLoad ? FWD_LOAD : FWD_MEM;
    end else if (hit[SLOT_WB]) begin
      sel = FWD_RF;
    end
  end

  // selects must be backed by the comparator bank's view of the stages
  always_comb begin
    if (sel == FWD_EX)
      p_ex_path_r2: assert (hit[SLOT_EX] && !exIsLoad)
        else $error("execute bypass chosen without execute match");
    if (sel == FWD_MEM)
      p_mem_path_r3: assert (hit[SLOT_MEM] && !hit[SLOT_EX] && !memIsLoad)
        else $error("memory bypass chosen without sole memory match");
    if (sel == FWD_LOAD)
      p_load_path_r6: assert (hit[SLOT_MEM] && !hit[SLOT_EX] && memIsLoad)
        else $error("load bypass chosen without memory load match");
    if (!srcValid)
      p_dead_src_r1: assert (hit == '0)
        else $error("match reported for an invalid consumer");
  end

endmodule

// File: rtl/hzd_stall_ctrl.sv
module hzd_stall_ctrl
  import hazard_pkg::*;
(
  input  logic         loadUseA,
  input  logic         loadUseB,
  input  fwdSel_e      selA,
  input  fwdSel_e      selB,
  output ctrlStrobes_t strobes
);

  logic needHold;
  assign needHold = loadUseA || loadUseB;

  always_comb begin
    strobes.holdFront    = needHold;
    strobes.injectBubble = needHold;
  end

  // a load-use hold always leaves at least one operand without a bypass
  always_comb begin
    if (strobes.holdFront)
      p_hold_no_bypass_r5: assert (selA == FWD_RF || selB == FWD_RF)
        else $error("hold raised while both operands bypass");
  end

endmodule

// File: rtl/hazard_interlock.sv
module hazard_interlock
  import hazard_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic              rdValid,
  input  logic [REG_AW-1:0] rdSrcA,
  input  logic [REG_AW-1:0] rdSrcB,
  input  logic              exValid,
  input  logic              exWrEn,
  input  logic              exIsLoad,
  input  logic [REG_AW-1:0] exDest,
  input  logic              memValid,
  input  logic              memWrEn,
  input  logic              memIsLoad,
  input  logic [REG_AW-1:0] memDest,
  input  logic              wbValid,
  input  logic              wbWrEn,
  input  logic [REG_AW-1:0] wbDest,
  output logic [1:0]        fwdSelA,
  output logic [1:0]        fwdSelB,
  output logic              stallUpstream,
  output logic              bubbleAlu
);

  localparam int unsigned NUM_SRC = 2;

  logic [NUM_OLDER-1:0]             prodValid;
  logic [NUM_OLDER-1:0]             prodWrEn;
  logic [NUM_OLDER-1:0][REG_AW-1:0] prodDest;
  logic [NUM_SRC-1:0][REG_AW-1:0]   srcRegs;
  fwdSel_e                          selArr [NUM_SRC];
  logic [NUM_SRC-1:0]               loadUse;
  ctrlStrobes_t                     strobes;

  assign prodValid = {wbValid, memValid, exValid};
  assign prodWrEn  = {wbWrEn, memWrEn, exWrEn};
  assign prodDest  = {wbDest, memDest, exDest};
  assign srcRegs   = {rdSrcB, rdSrcA};

  for (genvar s = 0; s < NUM_SRC; s++) begin : gSrc
    logic [NUM_OLDER-1:0] hit;

    hzd_match_bank #(.REG_AW(REG_AW)) u_match (
      .srcValid (rdValid),
      .srcReg   (srcRegs[s]),
      .prodValid(prodValid),
      .prodWrEn (prodWrEn),
      .prodDest (prodDest),
      .hit      (hit)
    );

    hzd_fwd_pick u_pick (
      .hit      (hit),
      .exIsLoad (exIsLoad),
      .memIsLoad(memIsLoad),
      .srcValid (rdValid),
      .sel      (selArr[s]),
      .loadUse  (loadUse[s])
    );
  end

  hzd_stall_ctrl u_ctrl (
    .loadUseA(loadUse[0]),
    .loadUseB(loadUse[1]),
    .selA    (selArr[0]),
    .selB    (selArr[1]),
    .strobes (strobes)
  );

  assign fwdSelA       = selArr[0];
  assign fwdSelB       = selArr[1];
  assign stallUpstream = strobes.holdFront;
  assign bubbleAlu     = strobes.injectBubble;

  // port-level guards
  always_comb begin
    if (!rdValid)
      p_idle_quiet_r1: assert (fwdSelA == 2'b00 && fwdSelB == 2'b00 && !stallUpstream)
        else $error("idle consumer produced a bypass or hold");
    if (rdSrcA == '0)
      p_zero_src_a_r7: assert (fwdSelA == 2'b00)
        else $error("register 0 bypassed on operand A");
    if (rdSrcB == '0)
      p_zero_src_b_r7: assert (fwdSelB == 2'b00)
        else $error("register 0 bypassed on operand B");
    if (stallUpstream)
      p_hold_needs_ex_load_r11: assert (exValid && exWrEn && exIsLoad)
        else $error("hold without a load in execute");
  end

endmodule

// File: tb/sim_hazard_interlock.sv
module sim_hazard_interlock;

  localparam int unsigned AW = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rdValid, exValid, exWrEn, exIsLoad, memValid, memWrEn, memIsLoad, wbValid, wbWrEn;
  logic [AW-1:0] rdSrcA, rdSrcB, exDest, memDest, wbDest;
  logic [1:0]    fwdSelA, fwdSelB;
  logic          stallUpstream, bubbleAlu;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  hazard_interlock #(.REG_AW(AW)) u0 (
    .rdValid(rdValid), .rdSrcA(rdSrcA), .rdSrcB(rdSrcB),
    .exValid(exValid), .exWrEn(exWrEn), .exIsLoad(exIsLoad), .exDest(exDest),
    .memValid(memValid), .memWrEn(memWrEn), .memIsLoad(memIsLoad), .memDest(memDest),
    .wbValid(wbValid), .wbWrEn(wbWrEn), .wbDest(wbDest),
    .fwdSelA(fwdSelA), .fwdSelB(fwdSelB),
    .stallUpstream(stallUpstream), .bubbleAlu(bubbleAlu)
  );

  // ---- reference model from the requirements ----
  function automatic logic producerMatch(input logic v, input logic w, input logic [AW-1:0] d,
                                         input logic [AW-1:0] src);
    return rdValid && v && w && (src != '0) && (d == src);
  endfunction

  function automatic logic [1:0] expSel(input logic [AW-1:0] src);
    if (producerMatch(exValid, exWrEn, exDest, src))
      return exIsLoad ? 2'b00 : 2'b01;
    if (producerMatch(memValid, memWrEn, memDest, src))
      return memIsLoad ? 2'b11 : 2'b10;
    return 2'b00;
  endfunction

  function automatic logic expStall();
    return exIsLoad && (producerMatch(exValid, exWrEn, exDest, rdSrcA) ||
                        producerMatch(exValid, exWrEn, exDest, rdSrcB));
  endfunction

  task automatic check(input string req, input string what, input logic [1:0] act, input logic [1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    check(req, "fwdSelA", fwdSelA, expSel(rdSrcA));
    check(req, "fwdSelB", fwdSelB, expSel(rdSrcB));
    check(req, "stallUpstream", {1'b0, stallUpstream}, {1'b0, expStall()});
    check(req, "bubbleAlu", {1'b0, bubbleAlu}, {1'b0, expStall()});
  endtask

  task automatic clearAll();
    rdValid = 0; rdSrcA = '0; rdSrcB = '0;
    exValid = 0; exWrEn = 0; exIsLoad = 0; exDest = '0;
    memValid = 0; memWrEn = 0; memIsLoad = 0; memDest = '0;
    wbValid = 0; wbWrEn = 0; wbDest = '0;
  endtask

  task automatic setEx(input logic v, input logic w, input logic ld, input logic [AW-1:0] d);
    exValid = v; exWrEn = w; exIsLoad = ld; exDest = d;
  endtask
  task automatic setMem(input logic v, input logic w, input logic ld, input logic [AW-1:0] d);
    memValid = v; memWrEn = w; memIsLoad = ld; memDest = d;
  endtask
  task automatic setWb(input logic v, input logic w, input logic [AW-1:0] d);
    wbValid = v; wbWrEn = w; wbDest = d;
  endtask
  task automatic setRd(input logic v, input logic [AW-1:0] a, input logic [AW-1:0] b);
    rdValid = v; rdSrcA = a; rdSrcB = b;
  endtask

  // inputs change on the falling edge, outputs sampled 2 ns later
  task automatic settle();
    #2;
  endtask

  initial begin
    int unsigned seedSink;
    seedSink = $urandom(32'd20240611);
    clearAll();

    // R1: reset/idle state, nothing valid
    @(negedge clk); settle();
    check("R1", "fwdSelA idle", fwdSelA, 2'b00);
    check("R1", "fwdSelB idle", fwdSelB, 2'b00);
    check("R1", "stall idle", {1'b0, stallUpstream}, 2'b00);

    // R1: consumer invalid while a load matches in execute
    @(negedge clk); clearAll(); setRd(0, 5'd3, 5'd3); setEx(1, 1, 1, 5'd3); settle();
    check("R1", "stall, consumer invalid", {1'b0, stallUpstream}, 2'b00);
    check("R1", "fwdSelA, consumer invalid", fwdSelA, 2'b00);

    // R2: execute ALU producer on operand A
    @(negedge clk); clearAll(); setRd(1, 5'd7, 5'd8); setEx(1, 1, 0, 5'd7); settle();
    check("R2", "fwdSelA exec bypass", fwdSelA, 2'b01);
    check("R10", "fwdSelB untouched", fwdSelB, 2'b00);

    // R3: memory ALU producer on operand B
    @(negedge clk); clearAll(); setRd(1, 5'd4, 5'd9); setMem(1, 1, 0, 5'd9); settle();
    check("R3", "fwdSelB mem bypass", fwdSelB, 2'b10);
    check("R3", "stall", {1'b0, stallUpstream}, 2'b00);

    // R4: producer three ahead only
    @(negedge clk); clearAll(); setRd(1, 5'd12, 5'd12); setWb(1, 1, 5'd12); settle();
    check("R4", "fwdSelA wb only", fwdSelA, 2'b00);
    check("R4", "stall wb only", {1'b0, stallUpstream}, 2'b00);

    // R5 / R12: load one ahead on operand B, then the same consumer a cycle later
    @(negedge clk); clearAll(); setRd(1, 5'd2, 5'd6); setEx(1, 1, 1, 5'd6); setMem(1, 1, 0, 5'd2); settle();
    check("R5", "stallUpstream load-use", {1'b0, stallUpstream}, 2'b01);
    check("R5", "bubbleAlu load-use", {1'b0, bubbleAlu}, 2'b01);
    check("R5", "fwdSelB load-use", fwdSelB, 2'b00);
    check("R10", "fwdSelA still mem bypass", fwdSelA, 2'b10);
    @(negedge clk); setEx(0, 0, 0, 5'd0); setMem(1, 1, 1, 5'd6); setWb(1, 1, 5'd2); settle();
    check("R12", "stall released", {1'b0, stallUpstream}, 2'b00);
    check("R12", "fwdSelB load data", fwdSelB, 2'b11);
    check("R6", "fwdSelB load data", fwdSelB, 2'b11);

    // R7: register 0 never matches
    @(negedge clk); clearAll(); setRd(1, 5'd0, 5'd0); setEx(1, 1, 1, 5'd0); setMem(1, 1, 0, 5'd0); settle();
    check("R7", "fwdSelA r0", fwdSelA, 2'b00);
    check("R7", "stall r0", {1'b0, stallUpstream}, 2'b00);

    // R8: invalid / non-writing producers ignored
    @(negedge clk); clearAll(); setRd(1, 5'd5, 5'd5); setEx(0, 1, 1, 5'd5); setMem(1, 0, 0, 5'd5); settle();
    check("R8", "fwdSelA disabled producers", fwdSelA, 2'b00);
    check("R8", "stall disabled load", {1'b0, stallUpstream}, 2'b00);
    @(negedge clk); setEx(1, 0, 1, 5'd5); setMem(0, 1, 1, 5'd5); settle();
    check("R8", "fwdSelB non-writing load", fwdSelB, 2'b00);
    check("R8", "stall non-writing load", {1'b0, stallUpstream}, 2'b00);

    // R9: youngest producer wins
    @(negedge clk); clearAll(); setRd(1, 5'd10, 5'd11);
    setEx(1, 1, 0, 5'd10); setMem(1, 1, 1, 5'd10); setWb(1, 1, 5'd10); settle();
    check("R9", "exec over mem", fwdSelA, 2'b01);
    @(negedge clk); setEx(1, 1, 0, 5'd3); setMem(1, 1, 1, 5'd11); setWb(1, 1, 5'd11); settle();
    check("R9", "mem over wb", fwdSelB, 2'b11);

    // R11: stall and bubble track together over random stage contents
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rdValid  = ($urandom % 8) != 0;
      rdSrcA   = AW'($urandom % 4);
      rdSrcB   = AW'($urandom % 4);
      setEx($urandom % 2 == 1, $urandom % 4 != 0, $urandom % 3 == 0, AW'($urandom % 4));
      setMem($urandom % 2 == 1, $urandom % 4 != 0, $urandom % 3 == 0, AW'($urandom % 4));
      setWb($urandom % 2 == 1, $urandom % 4 != 0, AW'($urandom % 4));
      settle();
      checkAll("R11");
      if (stallUpstream !== bubbleAlu) begin
        nChecks++; nFail++;
        $display("FAIL R11 bubble/stall mismatch: actual %0b expected %0b", bubbleAlu, stallUpstream);
      end
    end

    if (seedSink == 32'hFFFF_FFFF) $display("seed note");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!done && cycles > 100000) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule